// File: doc/BRIEF.md
# Doorbell-Keyed Two-Slot Ring Queue Binder

The block holds up to two ring-buffer queue contexts and binds each one to a doorbell key. A map request carries a doorbell offset, the memory address of a queue descriptor and the descriptor's packed fields. From these fields the block decodes the ring base, the ring size, the starting read and write pointers and the address where the read pointer is written back. It stores all of them in the lowest free slot. A downstream fetch engine reads each slot's contents from per-slot outputs.

An unmap request names a doorbell key. The block finds the valid slot that holds that key. It then asks for the descriptor to be written back to memory, carrying the slot's read and write pointers, through a valid/ready handshake. The slot is freed only when the writeback is accepted. A slot whose descriptor address is zero has no writeback: it is freed at once and a warning pulse is raised. A deallocate-all command walks both slots in order and unmaps each one whose key is nonzero. While a writeback or a walk is in progress the block reports busy and ignores new commands.

Top module: `dbq_mapper`

## Requirements
- R1: A map request stores key = offset << 2. It takes slot 0 when slot 0 is invalid, otherwise slot 1. The slot becomes valid on the clock edge that accepts the request.
- R2: A map request while both slots are valid sets `err_full`, which stays set until reset. Neither slot changes.
- R3: A mapped slot's base is the descriptor ring-base field shifted left by 8. Its size is 4 shifted left by bits [6:1] of the ring control word. The other control bits have no effect.
- R4: A mapped slot's read pointer is {rptr_hi, rptr_lo}, its write pointer is {wptr_hi, wptr_lo}, and its read-pointer writeback address is {rwb_hi, rwb_lo}.
- R5: An unmap that hits a valid slot with a nonzero descriptor address raises `wb_valid` in the next cycle. The writeback carries that slot's descriptor address and pointers, and `wb_sel` gives the slot. These outputs hold steady until `wb_ready`. On the accepting edge the slot becomes invalid and its key becomes 0.
- R6: An unmap that hits a slot whose descriptor address is 0 issues no writeback. The slot is freed on the request's edge and `warn_noaddr` is high for exactly one cycle.
- R7: An unmap whose key matches no valid slot sets the sticky `err_nomatch` and leaves both slots unchanged.
- R8: Deallocate-all treats slot 0 before slot 1. Each slot with a nonzero key goes through the R5 or R6 path. A slot whose key is 0 is skipped and stays valid. `busy` falls when the walk ends.
- R9: `busy` is high while a writeback is pending or a walk is running. Map, unmap and deallocate requests that arrive while busy are ignored.
- R10: When several requests arrive together while idle, map wins over unmap and unmap wins over deallocate. The losing requests are dropped.
- R11: After reset, both slots are invalid with key 0, and `wb_valid`, `busy`, both error flags and `warn_noaddr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_req | input | 1 | Map request strobe |
| map_db_off | input | DB_W | Doorbell offset of the queue being mapped |
| map_desc_addr | input | ADDR_W | Memory address of the descriptor (0 = none) |
| map_ring_ctl | input | 32 | Ring control word; bits [6:1] give the size exponent |
| map_ring_base | input | RB_W | Ring base field, in 256-byte units |
| map_rptr_lo | input | 32 | Read pointer, low word |
| map_rptr_hi | input | 32 | Read pointer, high word |
| map_wptr_lo | input | 32 | Write pointer, low word |
| map_wptr_hi | input | 32 | Write pointer, high word |
| map_rwb_lo | input | 32 | Read-pointer writeback address, low word |
| map_rwb_hi | input | 32 | Read-pointer writeback address, high word |
| unmap_req | input | 1 | Unmap request strobe |
| unmap_key | input | KEY_W | Doorbell key to unmap |
| dealloc_req | input | 1 | Deallocate-all strobe |
| wb_valid | output | 1 | Descriptor writeback request valid |
| wb_ready | input | 1 | Writeback accepted |
| wb_sel | output | 1 | Slot being written back |
| wb_addr | output | ADDR_W | Descriptor address for the writeback |
| wb_rptr | output | 64 | Read pointer to save |
| wb_wptr | output | 64 | Write pointer to save |
| busy | output | 1 | Writeback or walk in progress |
| err_full | output | 1 | Sticky: map request with no free slot |
| err_nomatch | output | 1 | Sticky: unmap key hit no slot |
| warn_noaddr | output | 1 | One-cycle pulse: slot freed without writeback |
| slot_valid | output | 2 | Valid bit per slot |
| slot_key | output | 2*KEY_W | Doorbell key per slot |
| slot_base | output | 2*ADDR_W | Ring base address per slot |
| slot_size | output | 2*SIZE_W | Ring size in bytes per slot |
| slot_rptr | output | 128 | Read pointer per slot |
| slot_wptr | output | 128 | Write pointer per slot |
| slot_rwb | output | 128 | Read-pointer writeback address per slot |

## Verification
A table of descriptors is mapped and unmapped one at a time. The table covers the smallest and largest size exponents, control words with stray bits set around the size field, and pointer words whose high halves are zero, all ones or mixed. These cases show whether the decode uses the right bit slice and whether the halves are in the right order. Directed sequences then fill both slots, which separates slot-0-first allocation from the full error. An unmap is held with ready low while a second command arrives, which shows whether the writeback holds steady and whether the busy gate works. A zero descriptor address and a zero doorbell key are mixed into deallocate-all walks, which tells the skip path apart from the warning path and checks that slot 0 is visited before slot 1.

// File: rtl/dbq_pkg.sv
// Shared types for the doorbell queue binder.
// Assumes: two slots, so a slot index is one bit wide.
package dbq_pkg;

    // Controller states: idle, walking slots for deallocate-all, awaiting writeback.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_WB   = 2'd2
    } dbq_state_e;

endpackage

// File: rtl/dbq_decode.sv
// Descriptor field decoder: turns the packed map-request fields into slot values.
// Purely combinational. Assumes RB_W + 8 <= ADDR_W so the scaled base fits.
module dbq_decode #(
    parameter int DB_W   = 10,
    parameter int RB_W   = 40,
    parameter int ADDR_W = 64,
    localparam int KEY_W  = DB_W + 2,
    localparam int SIZE_W = 66,
    localparam int PTR_W  = 64
) (
    input  logic [DB_W-1:0]   db_off,
    input  logic [31:0]       ring_ctl,
    input  logic [RB_W-1:0]   ring_base,
    input  logic [31:0]       rptr_lo,
    input  logic [31:0]       rptr_hi,
    input  logic [31:0]       wptr_lo,
    input  logic [31:0]       wptr_hi,
    input  logic [31:0]       rwb_lo,
    input  logic [31:0]       rwb_hi,
    output logic [KEY_W-1:0]  key,
    output logic [ADDR_W-1:0] base,
    output logic [SIZE_W-1:0] size,
    output logic [PTR_W-1:0]  rptr,
    output logic [PTR_W-1:0]  wptr,
    output logic [PTR_W-1:0]  rwb
);

    logic [5:0] size_exp;

    // Field extraction and scaling of every stored slot value.
    always_comb begin
        size_exp = ring_ctl[6:1];
        key      = {db_off, 2'b00};
        base     = ADDR_W'({ring_base, 8'h00});
        size     = SIZE_W'(4) << size_exp;
        rptr     = {rptr_hi, rptr_lo};
        wptr     = {wptr_hi, wptr_lo};
        rwb      = {rwb_hi, rwb_lo};
    end

endmodule

// File: rtl/dbq_slot.sv
// One queue-context slot: loads a decoded descriptor, frees on request.
// Assumes load and clear are never asserted together (controller guarantees it).
module dbq_slot #(
    parameter int KEY_W  = 12,
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 66,
    parameter int PTR_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic              clr,
    input  logic [KEY_W-1:0]  ld_key,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic [PTR_W-1:0]  ld_rptr,
    input  logic [PTR_W-1:0]  ld_wptr,
    input  logic [PTR_W-1:0]  ld_rwb,
    input  logic [ADDR_W-1:0] ld_desc,
    output logic              valid,
    output logic [KEY_W-1:0]  key,
    output logic [ADDR_W-1:0] base,
    output logic [SIZE_W-1:0] size,
    output logic [PTR_W-1:0]  rptr,
    output logic [PTR_W-1:0]  wptr,
    output logic [PTR_W-1:0]  rwb,
    output logic [ADDR_W-1:0] desc
);

    // Valid bit and doorbell key: set on load, cleared on free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            key   <= '0;
        end else if (ld) begin
            valid <= 1'b1;
            key   <= ld_key;
        end else if (clr) begin
            valid <= 1'b0;
            key   <= '0;
        end
    end

    // Context payload: captured on load, kept across a free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            size <= '0;
            rptr <= '0;
            wptr <= '0;
            rwb  <= '0;
            desc <= '0;
        end else if (ld) begin
            base <= ld_base;
            size <= ld_size;
            rptr <= ld_rptr;
            wptr <= ld_wptr;
            rwb  <= ld_rwb;
            desc <= ld_desc;
        end
    end

endmodule

// File: rtl/dbq_ctrl.sv
// Command controller: allocation order, key lookup, writeback handshake,
// deallocate-all walk and the error/warning flags.
// Assumes per-slot has_desc is high when the stored descriptor address is nonzero.
module dbq_ctrl
    import dbq_pkg::*;
#(
    parameter int KEY_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_req,
    input  logic               unmap_req,
    input  logic [KEY_W-1:0]   unmap_key,
    input  logic               dealloc_req,
    input  logic [1:0]         slot_valid,
    input  logic [2*KEY_W-1:0] slot_key,
    input  logic [1:0]         has_desc,
    input  logic               wb_ready,
    output logic [1:0]         ld,
    output logic [1:0]         clr,
    output logic               wb_valid,
    output logic               wb_sel,
    output logic               busy,
    output logic               err_full,
    output logic               err_nomatch,
    output logic               warn_noaddr
);

    dbq_state_e state, state_n;
    logic       cur, cur_n;
    logic       scan_idx, scan_n;
    logic       from_scan, from_scan_n;
    logic       full_set, nomatch_set, warn_set;
    logic [1:0] hit;
    logic       hsel;

    // Key lookup against valid slots; slot 0 takes precedence.
    always_comb begin
        for (int s = 0; s < 2; s++) begin
            hit[s] = slot_valid[s] && (slot_key[s*KEY_W +: KEY_W] == unmap_key);
        end
        hsel = !hit[0];
    end

    // Next-state, slot strobes and flag set pulses.
    always_comb begin
        state_n     = state;
        cur_n       = cur;
        scan_n      = scan_idx;
        from_scan_n = from_scan;
        ld          = 2'b00;
        clr         = 2'b00;
        full_set    = 1'b0;
        nomatch_set = 1'b0;
        warn_set    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (map_req) begin
                    if (!slot_valid[0])      ld[0]    = 1'b1;
                    else if (!slot_valid[1]) ld[1]    = 1'b1;
                    else                     full_set = 1'b1;
                end else if (unmap_req) begin
                    if (|hit) begin
                        if (has_desc[hsel]) begin
                            state_n     = ST_WB;
                            cur_n       = hsel;
                            from_scan_n = 1'b0;
                        end else begin
                            clr[hsel] = 1'b1;
                            warn_set  = 1'b1;
                        end
                    end else begin
                        nomatch_set = 1'b1;
                    end
                end else if (dealloc_req) begin
                    state_n = ST_SCAN;
                    scan_n  = 1'b0;
                end
            end
            ST_SCAN: begin
                if (slot_valid[scan_idx] && (slot_key[scan_idx*KEY_W +: KEY_W] != '0)
                    && has_desc[scan_idx]) begin
                    state_n     = ST_WB;
                    cur_n       = scan_idx;
                    from_scan_n = 1'b1;
                end else begin
                    if (slot_valid[scan_idx] && (slot_key[scan_idx*KEY_W +: KEY_W] != '0)) begin
                        clr[scan_idx] = 1'b1;
                        warn_set      = 1'b1;
                    end
                    if (scan_idx) state_n = ST_IDLE;
                    else          scan_n  = 1'b1;
                end
            end
            ST_WB: begin
                if (wb_ready) begin
                    clr[cur] = 1'b1;
                    if (from_scan && !cur) begin
                        state_n = ST_SCAN;
                        scan_n  = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State, slot pointer and walk position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur       <= 1'b0;
            scan_idx  <= 1'b0;
            from_scan <= 1'b0;
        end else begin
            state     <= state_n;
            cur       <= cur_n;
            scan_idx  <= scan_n;
            from_scan <= from_scan_n;
        end
    end

    // Sticky error flags and the one-cycle warning pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_full    <= 1'b0;
            err_nomatch <= 1'b0;
            warn_noaddr <= 1'b0;
        end else begin
            err_full    <= err_full | full_set;
            err_nomatch <= err_nomatch | nomatch_set;
            warn_noaddr <= warn_set;
        end
    end

    assign wb_valid = (state == ST_WB);
    assign wb_sel   = cur;
    assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/dbq_mapper.sv
// Two-slot doorbell queue binder top: decodes map descriptors, holds two
// queue contexts and issues descriptor writebacks on unmap.
// Assumes a descriptor address of 0 means "no descriptor to write back".
module dbq_mapper #(
    parameter int DB_W   = 10,
    parameter int RB_W   = 40,
    parameter int ADDR_W = 64,
    localparam int KEY_W  = DB_W + 2,
    localparam int SIZE_W = 66,
    localparam int PTR_W  = 64,
    localparam int NSLOT  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      map_req,
    input  logic [DB_W-1:0]           map_db_off,
    input  logic [ADDR_W-1:0]         map_desc_addr,
    input  logic [31:0]               map_ring_ctl,
    input  logic [RB_W-1:0]           map_ring_base,
    input  logic [31:0]               map_rptr_lo,
    input  logic [31:0]               map_rptr_hi,
    input  logic [31:0]               map_wptr_lo,
    input  logic [31:0]               map_wptr_hi,
    input  logic [31:0]               map_rwb_lo,
    input  logic [31:0]               map_rwb_hi,
    input  logic                      unmap_req,
    input  logic [KEY_W-1:0]          unmap_key,
    input  logic                      dealloc_req,
    output logic                      wb_valid,
    input  logic                      wb_ready,
    output logic                      wb_sel,
    output logic [ADDR_W-1:0]         wb_addr,
    output logic [PTR_W-1:0]          wb_rptr,
    output logic [PTR_W-1:0]          wb_wptr,
    output logic                      busy,
    output logic                      err_full,
    output logic                      err_nomatch,
    output logic                      warn_noaddr,
    output logic [NSLOT-1:0]          slot_valid,
    output logic [NSLOT*KEY_W-1:0]    slot_key,
    output logic [NSLOT*ADDR_W-1:0]   slot_base,
    output logic [NSLOT*SIZE_W-1:0]   slot_size,
    output logic [NSLOT*PTR_W-1:0]    slot_rptr,
    output logic [NSLOT*PTR_W-1:0]    slot_wptr,
    output logic [NSLOT*PTR_W-1:0]    slot_rwb
);

    logic [KEY_W-1:0]        d_key;
    logic [ADDR_W-1:0]       d_base;
    logic [SIZE_W-1:0]       d_size;
    logic [PTR_W-1:0]        d_rptr, d_wptr, d_rwb;
    logic [NSLOT-1:0]        ld, clr, has_desc;
    logic [NSLOT*ADDR_W-1:0] slot_desc;

    dbq_decode #(.DB_W(DB_W), .RB_W(RB_W), .ADDR_W(ADDR_W)) u_dec (
        .db_off    (map_db_off),
        .ring_ctl  (map_ring_ctl),
        .ring_base (map_ring_base),
        .rptr_lo   (map_rptr_lo),
        .rptr_hi   (map_rptr_hi),
        .wptr_lo   (map_wptr_lo),
        .wptr_hi   (map_wptr_hi),
        .rwb_lo    (map_rwb_lo),
        .rwb_hi    (map_rwb_hi),
        .key       (d_key),
        .base      (d_base),
        .size      (d_size),
        .rptr      (d_rptr),
        .wptr      (d_wptr),
        .rwb       (d_rwb)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        dbq_slot #(.KEY_W(KEY_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PTR_W(PTR_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld      (ld[s]),
            .clr     (clr[s]),
            .ld_key  (d_key),
            .ld_base (d_base),
            .ld_size (d_size),
            .ld_rptr (d_rptr),
            .ld_wptr (d_wptr),
            .ld_rwb  (d_rwb),
            .ld_desc (map_desc_addr),
            .valid   (slot_valid[s]),
            .key     (slot_key[s*KEY_W +: KEY_W]),
            .base    (slot_base[s*ADDR_W +: ADDR_W]),
            .size    (slot_size[s*SIZE_W +: SIZE_W]),
            .rptr    (slot_rptr[s*PTR_W +: PTR_W]),
            .wptr    (slot_wptr[s*PTR_W +: PTR_W]),
            .rwb     (slot_rwb[s*PTR_W +: PTR_W]),
            .desc    (slot_desc[s*ADDR_W +: ADDR_W])
        );
        assign has_desc[s] = (slot_desc[s*ADDR_W +: ADDR_W] != '0);
    end

    dbq_ctrl #(.KEY_W(KEY_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .map_req     (map_req),
        .unmap_req   (unmap_req),
        .unmap_key   (unmap_key),
        .dealloc_req (dealloc_req),
        .slot_valid  (slot_valid),
        .slot_key    (slot_key),
        .has_desc    (has_desc),
        .wb_ready    (wb_ready),
        .ld          (ld),
        .clr         (clr),
        .wb_valid    (wb_valid),
        .wb_sel      (wb_sel),
        .busy        (busy),
        .err_full    (err_full),
        .err_nomatch (err_nomatch),
        .warn_noaddr (warn_noaddr)
    );

    // Writeback payload taken from the slot under writeback.
    always_comb begin
        wb_addr = slot_desc[wb_sel*ADDR_W +: ADDR_W];
        wb_rptr = slot_rptr[wb_sel*PTR_W +: PTR_W];
        wb_wptr = slot_wptr[wb_sel*PTR_W +: PTR_W];
    end

endmodule

// File: rtl/dbq_mapper_chk.sv
// Protocol checker for dbq_mapper, attached by bind. Observes ports only.
module dbq_mapper_chk #(
    parameter int KEY_W  = 12,
    parameter int ADDR_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               map_req,
    input logic               unmap_req,
    input logic [KEY_W-1:0]   unmap_key,
    input logic               wb_valid,
    input logic               wb_ready,
    input logic               wb_sel,
    input logic [ADDR_W-1:0]  wb_addr,
    input logic [63:0]        wb_rptr,
    input logic [63:0]        wb_wptr,
    input logic               busy,
    input logic               err_full,
    input logic               err_nomatch,
    input logic [1:0]         slot_valid,
    input logic [2*KEY_W-1:0] slot_key
);

    logic any_hit;
    assign any_hit = (slot_valid[0] && slot_key[KEY_W-1:0] == unmap_key)
                  || (slot_valid[1] && slot_key[2*KEY_W-1:KEY_W] == unmap_key);

    // R1
    slot0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_req && !busy && !slot_valid[0]) |=> (slot_valid[0] && slot_valid[1] == $past(slot_valid[1])));

    // R2
    full_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_req && !busy && slot_valid == 2'b11) |=> (err_full && slot_valid == 2'b11));

    // R2
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_full |=> err_full);

    // R5
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_sel) && $stable(wb_addr)
                                     && $stable(wb_rptr) && $stable(wb_wptr)));

    // R5
    wb_free0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ready && !wb_sel) |=> !slot_valid[0]);

    // R5
    wb_free1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ready && wb_sel) |=> !slot_valid[1]);

    // R7
    nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unmap_req && !map_req && !busy && !any_hit) |=> (err_nomatch && $stable(slot_valid)));

    // R9
    wb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> busy);

    // R9
    busy_nomap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!$rose(slot_valid[0]) && !$rose(slot_valid[1])));

endmodule

bind dbq_mapper dbq_mapper_chk #(.KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .map_req     (map_req),
    .unmap_req   (unmap_req),
    .unmap_key   (unmap_key),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_sel      (wb_sel),
    .wb_addr     (wb_addr),
    .wb_rptr     (wb_rptr),
    .wb_wptr     (wb_wptr),
    .busy        (busy),
    .err_full    (err_full),
    .err_nomatch (err_nomatch),
    .slot_valid  (slot_valid),
    .slot_key    (slot_key)
);

// File: tb/dbq_mapper_tb.sv
module dbq_mapper_tb;

    localparam int DB_W = 10, RB_W = 40, ADDR_W = 64;
    localparam int KEY_W = DB_W + 2, SIZE_W = 66;
    localparam int NV = 4;

    // Descriptor vectors: offset, control word, base field, pointer words, desc addr.
    localparam logic [DB_W-1:0] V_OFF [NV] = '{10'd1, 10'd513, 10'd1023, 10'd77};
    localparam logic [31:0] V_CTL [NV] = '{32'h0000_0000, 32'h0000_007E, 32'hFFFF_FF81, 32'h0000_0015};
    localparam logic [RB_W-1:0] V_RB [NV] = '{40'h1, 40'hFF_FFFF_FFFF, 40'h12_3456_789A, 40'h0};
    localparam logic [31:0] V_RPL [NV] = '{32'h10, 32'hFFFF_FFFF, 32'h0, 32'hDEAD_BEEF};
    localparam logic [31:0] V_RPH [NV] = '{32'h0, 32'hFFFF_FFFF, 32'h1, 32'h0BAD_F00D};
    localparam logic [31:0] V_WPL [NV] = '{32'h20, 32'h0, 32'hFFFF_FFFF, 32'h1357_9BDF};
    localparam logic [31:0] V_WPH [NV] = '{32'h0, 32'h8000_0000, 32'h0, 32'h2468_ACE0};
    localparam logic [63:0] V_DA  [NV] = '{64'h1000, 64'hFFFF_FFFF_FFFF_F000, 64'h40, 64'h8_0000_0000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic map_req = 0, unmap_req = 0, dealloc_req = 0, wb_ready = 0;
    logic [DB_W-1:0] map_db_off = '0;
    logic [ADDR_W-1:0] map_desc_addr = '0;
    logic [31:0] map_ring_ctl = '0;
    logic [RB_W-1:0] map_ring_base = '0;
    logic [31:0] map_rptr_lo = '0, map_rptr_hi = '0, map_wptr_lo = '0, map_wptr_hi = '0;
    logic [31:0] map_rwb_lo = '0, map_rwb_hi = '0;
    logic [KEY_W-1:0] unmap_key = '0;
    logic wb_valid, wb_sel, busy, err_full, err_nomatch, warn_noaddr;
    logic [ADDR_W-1:0] wb_addr;
    logic [63:0] wb_rptr, wb_wptr;
    logic [1:0] slot_valid;
    logic [2*KEY_W-1:0] slot_key;
    logic [2*ADDR_W-1:0] slot_base;
    logic [2*SIZE_W-1:0] slot_size;
    logic [127:0] slot_rptr, slot_wptr, slot_rwb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dbq_mapper #(.DB_W(DB_W), .RB_W(RB_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .map_req(map_req), .map_db_off(map_db_off),
        .map_desc_addr(map_desc_addr), .map_ring_ctl(map_ring_ctl), .map_ring_base(map_ring_base),
        .map_rptr_lo(map_rptr_lo), .map_rptr_hi(map_rptr_hi), .map_wptr_lo(map_wptr_lo),
        .map_wptr_hi(map_wptr_hi), .map_rwb_lo(map_rwb_lo), .map_rwb_hi(map_rwb_hi),
        .unmap_req(unmap_req), .unmap_key(unmap_key), .dealloc_req(dealloc_req),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_sel(wb_sel), .wb_addr(wb_addr),
        .wb_rptr(wb_rptr), .wb_wptr(wb_wptr), .busy(busy), .err_full(err_full),
        .err_nomatch(err_nomatch), .warn_noaddr(warn_noaddr), .slot_valid(slot_valid),
        .slot_key(slot_key), .slot_base(slot_base), .slot_size(slot_size),
        .slot_rptr(slot_rptr), .slot_wptr(slot_wptr), .slot_rwb(slot_rwb)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_map(input logic [DB_W-1:0] off, input logic [63:0] da);
        map_db_off = off;
        map_desc_addr = da;
        map_req = 1'b1;
        step();
        map_req = 1'b0;
    endtask

    task automatic do_unmap(input logic [KEY_W-1:0] k);
        unmap_key = k;
        unmap_req = 1'b1;
        step();
        unmap_req = 1'b0;
    endtask

    task automatic accept();
        wb_ready = 1'b1;
        step();
        wb_ready = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 valid", 128'(slot_valid), 128'(0));
        chk("R11 keys", 128'(slot_key), 128'(0));
        chk("R11 flags", 128'({wb_valid, busy, err_full, err_nomatch, warn_noaddr}), 128'(0));

        // Vector table: map into slot 0, check decode, unmap with writeback.
        for (int i = 0; i < NV; i++) begin
            map_ring_ctl = V_CTL[i];
            map_ring_base = V_RB[i];
            map_rptr_lo = V_RPL[i]; map_rptr_hi = V_RPH[i];
            map_wptr_lo = V_WPL[i]; map_wptr_hi = V_WPH[i];
            map_rwb_lo = V_WPL[i] ^ 32'h5A5A_0000; map_rwb_hi = V_RPH[i] ^ 32'h0000_A5A5;
            do_map(V_OFF[i], V_DA[i]);
            chk("R1 valid", 128'(slot_valid), 128'(2'b01));
            chk("R1 key", 128'(slot_key[KEY_W-1:0]), 128'(V_OFF[i]) << 2);
            chk("R3 base", 128'(slot_base[ADDR_W-1:0]), 128'(V_RB[i]) << 8);
            chk("R3 size", 128'(slot_size[SIZE_W-1:0]), 128'(4) << V_CTL[i][6:1]);
            chk("R4 rptr", 128'(slot_rptr[63:0]), 128'({V_RPH[i], V_RPL[i]}));
            chk("R4 wptr", 128'(slot_wptr[63:0]), 128'({V_WPH[i], V_WPL[i]}));
            chk("R4 rwb", 128'(slot_rwb[63:0]),
                128'({V_RPH[i] ^ 32'h0000_A5A5, V_WPL[i] ^ 32'h5A5A_0000}));
            do_unmap(KEY_W'({V_OFF[i], 2'b00}));
            chk("R5 wb_valid", 128'({wb_valid, busy, wb_sel}), 128'(3'b110));
            chk("R5 wb_addr", 128'(wb_addr), 128'(V_DA[i]));
            chk("R5 wb_rptr", 128'(wb_rptr), 128'({V_RPH[i], V_RPL[i]}));
            chk("R5 wb_wptr", 128'(wb_wptr), 128'({V_WPH[i], V_WPL[i]}));
            accept();
            chk("R5 freed", 128'({slot_valid[0], slot_key[KEY_W-1:0], busy}), 128'(0));
        end

        // Two slots, full error, unmatched unmap.
        do_map(10'd5, 64'h100);
        do_map(10'd9, 64'h200);
        chk("R1 second slot", 128'({slot_valid, slot_key[2*KEY_W-1:KEY_W]}), 128'({2'b11, 12'd36}));
        do_map(10'd11, 64'h300);
        chk("R2 full", 128'({err_full, slot_valid, slot_key}), 128'({1'b1, 2'b11, 12'd36, 12'd20}));
        do_unmap(12'd99);
        chk("R7 nomatch", 128'({err_nomatch, slot_valid, busy}), 128'({1'b1, 2'b11, 1'b0}));

        // Writeback held with ready low; a command while busy is ignored.
        do_unmap(12'd36);
        chk("R5 sel1", 128'({wb_valid, wb_sel, wb_addr}), 128'({1'b1, 1'b1, 64'h200}));
        do_unmap(12'd20);
        step();
        chk("R5 hold", 128'({wb_valid, wb_sel, wb_addr}), 128'({1'b1, 1'b1, 64'h200}));
        chk("R9 busy ignore", 128'({busy, slot_valid}), 128'({1'b1, 2'b11}));
        accept();
        chk("R9 after", 128'({busy, slot_valid, slot_key[KEY_W-1:0]}), 128'({1'b0, 2'b01, 12'd20}));

        // No descriptor address: immediate free and warning pulse.
        do_map(10'd3, 64'h0);
        do_unmap(12'd12);
        chk("R6 warn", 128'({warn_noaddr, wb_valid, busy, slot_valid}), 128'({3'b100, 2'b01}));
        step();
        chk("R6 pulse", 128'(warn_noaddr), 128'(0));

        // Deallocate-all skipping a zero key in slot 0.
        do_unmap(12'd20);
        accept();
        do_map(10'd0, 64'h300);
        do_map(10'd7, 64'h400);
        dealloc_req = 1'b1; step(); dealloc_req = 1'b0;
        step();
        step();
        chk("R8 skip key0", 128'({wb_valid, wb_sel, wb_addr}), 128'({1'b1, 1'b1, 64'h400}));
        accept();
        chk("R8 slot0 kept", 128'({busy, slot_valid}), 128'({1'b0, 2'b01}));

        // Deallocate-all over both slots, slot 1 without address.
        do_unmap(12'd0);
        accept();
        do_map(10'd1, 64'h500);
        do_map(10'd2, 64'h0);
        dealloc_req = 1'b1; step(); dealloc_req = 1'b0;
        step();
        chk("R8 slot0 first", 128'({wb_valid, wb_sel, wb_addr}), 128'({1'b1, 1'b0, 64'h500}));
        accept();
        chk("R8 slot0 freed", 128'({busy, slot_valid}), 128'({1'b1, 2'b10}));
        step();
        chk("R8 slot1 warn", 128'({busy, slot_valid, warn_noaddr}), 128'({1'b0, 2'b00, 1'b1}));

        // Simultaneous map and unmap: map wins.
        map_db_off = 10'd4; map_desc_addr = 64'h600;
        unmap_key = 12'd16;
        map_req = 1'b1; unmap_req = 1'b1; dealloc_req = 1'b1;
        step();
        map_req = 1'b0; unmap_req = 1'b0; dealloc_req = 1'b0;
        chk("R10 priority", 128'({slot_valid, wb_valid, busy}), 128'({2'b01, 2'b00}));
        chk("R2 sticky", 128'({err_full, err_nomatch}), 128'(2'b11));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule